// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the line and frame timing for a streaming RGB video output. It drives horizontal sync, vertical sync, data enable, a gated pixel bus and the column and row of the current pixel inside the visible area. Software sets it up through a small word-addressed register port. It writes the eight phase lengths, the polarity of each output and the interrupt mask, and then starts or stops the raster with a command bit.

Each line runs through four phases: sync, back porch, visible data, front porch. The row counter moves on once at the end of every line, and the rows pass through the same four phases. Every phase length is written as the wanted count minus one. A status bit is set at the first cycle of each frame, which is also where vertical sync begins. That status bit, gated by a mask bit, drives the interrupt line.

Top module: `raster_timing`

## Requirements
- R1: A phase whose length field holds N lasts N+1 clock cycles. Total line length is the sum of the four horizontal fields plus 4. Total frame length in lines is the sum of the four vertical fields plus 4.
- R2: Within a line the phases run in the order sync, back porch, visible, front porch, starting at column count 0. The row count advances only when a line ends, and rows follow the same phase order.
- R3: Data enable is active only when both column and row are in their visible phases. x_o and y_o give the offset from the first visible column and row while data enable is active, and are 0 otherwise.
- R4: Register 3 holds the polarity bits: bit 0 hsync, bit 1 vsync, bit 2 data enable, bit 3 pixel data. A 1 means active high and a 0 means active low. pix_o carries pix_i while data enable is active and zero otherwise, and is bitwise inverted when bit 3 is 0.
- R5: Writing 1 to bit 0 of register 0 starts the raster and writing 0 stops it. While stopped, the counters are held at zero, hsync, vsync and data enable sit at their inactive levels, and x_o and y_o are 0.
- R6: Bit 0 of register 2 is a sticky status bit. It is set in the first cycle of every frame. Writing 1 to it clears it and writing 0 has no effect. If a clear and a frame start fall in the same cycle, the bit stays set.
- R7: irq_o equals status bit 0 AND bit 0 of the mask in register 1. All mask bits are stored and read back, so a read-modify-write of bit 0 leaves the other mask bits unchanged.
- R8: The timing fields sit at registers 4 to 7 (horizontal sync, back porch, visible, front porch) and 8 to 11 (the same four for vertical), and they read back as written. A field written while the raster runs takes effect at the start of the next frame. While stopped, a written field takes effect at once.
- R9: After reset every register reads 0, the raster is stopped and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| pix_i | input | PW | Pixel data from the fetch path |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pix_o | output | PW | Gated pixel data, polarity applied |
| x_o | output | CW | Column inside the visible area |
| y_o | output | CW | Row inside the visible area |
| irq_o | output | 1 | Masked frame interrupt |

## Verification
Two events can land in the same cycle: the start-of-frame event that sets the status bit, and a software write of 1 that clears it. The bench starts the raster and then issues the clear write on the very next cycle, which is the first cycle of the frame. After that, a status read must return 1. A second clear, placed a few cycles into the frame, must read back 0. The status must then show 1 again once the next frame has begun. That same run also rewrites the visible width partway through a frame. The scoreboard expects the old width for the current frame and the new width only for the frame that follows.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int ADDR_W = 4;
  localparam int NPOL   = 4;

  // register word addresses
  localparam logic [ADDR_W-1:0] ADR_CMD   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_IMASK = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_ISTAT = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_POL   = 4'd3;

  // polarity bit positions
  localparam int POL_HS  = 0;
  localparam int POL_VS  = 1;
  localparam int POL_DE  = 2;
  localparam int POL_PIX = 3;

  // phase index inside one axis configuration (also the register order)
  localparam int PH_SYNC = 0;
  localparam int PH_BACK = 1;
  localparam int PH_VIS  = 2;
  localparam int PH_FRNT = 3;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 16,
  parameter int MW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic                   frame_start,
  input  logic                   frame_end,
  output logic                   run,
  output logic [NPOL-1:0]        pol,
  output logic [MW-1:0]          mask,
  output logic                   stat,
  output logic                   irq,
  output logic [1:0][3:0][CW-1:0] live_cfg
);
  logic                    run_q, run_d;
  logic [NPOL-1:0]         pol_q, pol_d;
  logic [MW-1:0]           mask_q, mask_d;
  logic                    stat_q, stat_d;
  logic [1:0][3:0][CW-1:0] sh_q, sh_d;
  logic [1:0][3:0][CW-1:0] live_q, live_d;
  logic                    reload;

  // next state: software writes, sticky status, frame-aligned reload
  always_comb begin
    run_d  = run_q;
    pol_d  = pol_q;
    mask_d = mask_q;
    stat_d = stat_q;
    sh_d   = sh_q;
    if (wr) begin
      case (addr)
        ADR_CMD:   run_d  = wdata[0];
        ADR_IMASK: mask_d = wdata[MW-1:0];
        ADR_ISTAT: if (wdata[0]) stat_d = 1'b0;
        ADR_POL:   pol_d  = wdata[NPOL-1:0];
        default: begin
          if (addr[3])      sh_d[1][addr[1:0]] = wdata[CW-1:0];
          else if (addr[2]) sh_d[0][addr[1:0]] = wdata[CW-1:0];
        end
      endcase
    end
    if (frame_start) stat_d = 1'b1;
  end

  assign reload = !run_q || frame_end;
  assign live_d = reload ? sh_q : live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pol_q  <= '0;
      mask_q <= '0;
      stat_q <= 1'b0;
      sh_q   <= '0;
      live_q <= '0;
    end else begin
      run_q  <= run_d;
      pol_q  <= pol_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      sh_q   <= sh_d;
      if (reload) live_q <= live_d;
    end
  end

  always_comb begin
    case (addr)
      ADR_CMD:   rdata = DW'(run_q);
      ADR_IMASK: rdata = DW'(mask_q);
      ADR_ISTAT: rdata = DW'(stat_q);
      ADR_POL:   rdata = DW'(pol_q);
      default: begin
        if (addr[3])      rdata = DW'(sh_q[1][addr[1:0]]);
        else if (addr[2]) rdata = DW'(sh_q[0][addr[1:0]]);
        else              rdata = '0;
      end
    endcase
  end

  assign run      = run_q;
  assign pol      = pol_q;
  assign mask     = mask_q;
  assign stat     = stat_q;
  assign irq      = stat_q & mask_q[0];
  assign live_cfg = live_q;
endmodule

// File: rtl/raster_phase.sv
module raster_phase
  import raster_pkg::*;
#(
  parameter int CW  = 10,
  localparam int CTW = CW + 2
) (
  input  logic [CTW-1:0]     cnt,
  input  logic [3:0][CW-1:0] cfg,
  output logic               in_sync,
  output logic               in_vis,
  output logic               last,
  output logic [CW-1:0]      pos
);
  logic [CTW-1:0] sync_end, back_end, vis_end, final_cnt;

  assign sync_end  = CTW'(cfg[PH_SYNC]) + CTW'(1);
  assign back_end  = sync_end + CTW'(cfg[PH_BACK]) + CTW'(1);
  assign vis_end   = back_end + CTW'(cfg[PH_VIS]) + CTW'(1);
  assign final_cnt = vis_end + CTW'(cfg[PH_FRNT]);

  assign in_sync = cnt < sync_end;
  assign in_vis  = (cnt >= back_end) && (cnt < vis_end);
  assign last    = cnt == final_cnt;

  logic [CTW-1:0] offs;
  assign offs = cnt - back_end;
  assign pos  = in_vis ? offs[CW-1:0] : '0;
endmodule

// File: rtl/raster_scan.sv
module raster_scan #(
  parameter int CW  = 10,
  localparam int CTW = CW + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [1:0][3:0][CW-1:0] cfg,
  output logic [1:0][CTW-1:0]     cnt,
  output logic [1:0]              in_sync,
  output logic [1:0]              in_vis,
  output logic [1:0][CW-1:0]      pos,
  output logic                    frame_start,
  output logic                    frame_end
);
  logic [1:0][CTW-1:0] cnt_q, cnt_d;
  logic [1:0]          last;

  // axis 0 = column, axis 1 = row
  for (genvar a = 0; a < 2; a++) begin : g_axis
    raster_phase #(.CW(CW)) u_phase (
      .cnt     (cnt_q[a]),
      .cfg     (cfg[a]),
      .in_sync (in_sync[a]),
      .in_vis  (in_vis[a]),
      .last    (last[a]),
      .pos     (pos[a])
    );
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (last[0]) begin
      cnt_d[0] = '0;
      cnt_d[1] = last[1] ? '0 : cnt_q[1] + CTW'(1);
    end else begin
      cnt_d[0] = cnt_q[0] + CTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt         = cnt_q;
  assign frame_start = run && (cnt_q[0] == '0) && (cnt_q[1] == '0);
  assign frame_end   = run && last[0] && last[1];
endmodule

// File: rtl/raster_out.sv
module raster_out
  import raster_pkg::*;
#(
  parameter int CW = 10,
  parameter int PW = 8
) (
  input  logic               run,
  input  logic [NPOL-1:0]    pol,
  input  logic [1:0]         in_sync,
  input  logic [1:0]         in_vis,
  input  logic [1:0][CW-1:0] pos,
  input  logic [PW-1:0]      pix_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [PW-1:0]      pix_o,
  output logic [CW-1:0]      x_o,
  output logic [CW-1:0]      y_o
);
  logic hs_act, vs_act, de_act;

  assign hs_act = run && in_sync[0];
  assign vs_act = run && in_sync[1];
  assign de_act = run && in_vis[0] && in_vis[1];

  // a polarity bit of 0 inverts the active-high internal level
  assign hsync_o = hs_act ^ ~pol[POL_HS];
  assign vsync_o = vs_act ^ ~pol[POL_VS];
  assign de_o    = de_act ^ ~pol[POL_DE];
  assign pix_o   = (de_act ? pix_i : '0) ^ {PW{~pol[POL_PIX]}};
  assign x_o     = de_act ? pos[0] : '0;
  assign y_o     = de_act ? pos[1] : '0;
endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 16,
  parameter int PW = 8,
  parameter int MW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [PW-1:0]     pix_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [PW-1:0]     pix_o,
  output logic [CW-1:0]     x_o,
  output logic [CW-1:0]     y_o,
  output logic              irq_o
);
  localparam int CTW = CW + 2;

  logic                    run, stat, frame_start, frame_end;
  logic [NPOL-1:0]         pol;
  logic [MW-1:0]           mask;
  logic [1:0][3:0][CW-1:0] live_cfg;
  logic [1:0][CTW-1:0]     cnt;
  logic [1:0]              in_sync, in_vis;
  logic [1:0][CW-1:0]      pos;
  logic [CTW-1:0]          hcnt, vcnt;

  raster_regs #(.CW(CW), .DW(DW), .MW(MW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .rdata       (bus_rdata),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .run         (run),
    .pol         (pol),
    .mask        (mask),
    .stat        (stat),
    .irq         (irq_o),
    .live_cfg    (live_cfg)
  );

  raster_scan #(.CW(CW)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cfg         (live_cfg),
    .cnt         (cnt),
    .in_sync     (in_sync),
    .in_vis      (in_vis),
    .pos         (pos),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  raster_out #(.CW(CW), .PW(PW)) u_out (
    .run     (run),
    .pol     (pol),
    .in_sync (in_sync),
    .in_vis  (in_vis),
    .pos     (pos),
    .pix_i   (pix_i),
    .hsync_o (hsync_o),
    .vsync_o (vsync_o),
    .de_o    (de_o),
    .pix_o   (pix_o),
    .x_o     (x_o),
    .y_o     (y_o)
  );

  assign hcnt = cnt[0];
  assign vcnt = cnt[1];
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int CTW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [3:0]     pol,
  input logic           mask0,
  input logic           stat,
  input logic           frame_start,
  input logic           irq_o,
  input logic           hsync_o,
  input logic           de_o,
  input logic [CTW-1:0] hcnt,
  input logic [CTW-1:0] vcnt
);
  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == '0 && vcnt == '0));

  assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && hcnt != '0) |-> hcnt == $past(hcnt) + CTW'(1));

  assert_row_at_line_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && vcnt != $past(vcnt)) |-> hcnt == '0);

  assert_de_not_in_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o == pol[2]) |-> (hsync_o != pol[0]));

  assert_frame_sets_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> stat);

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask0 |-> !irq_o);
endmodule

bind raster_timing raster_timing_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .pol         (pol),
  .mask0       (mask[0]),
  .stat        (stat),
  .frame_start (frame_start),
  .irq_o       (irq_o),
  .hsync_o     (hsync_o),
  .de_o        (de_o),
  .hcnt        (hcnt),
  .vcnt        (vcnt)
);

// File: tb/raster_timing_bench.sv
module raster_timing_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int DW = 16;
  localparam int PW = 8;

  typedef struct packed {
    logic          hs;
    logic          vs;
    logic          de;
    logic [PW-1:0] pix;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [3:0]    bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [PW-1:0] pix_i;
  logic          hsync_o, vsync_o, de_o, irq_o;
  logic [PW-1:0] pix_o;
  logic [CW-1:0] x_o, y_o;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing u_raster_timing (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_i(pix_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o),
    .x_o(x_o), .y_o(y_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // driver side of the scoreboard: one expected item per cycle of a frame
  task automatic push_frame(input int hs, input int hb, input int ha, input int hf,
                            input int vs, input int vb, input int va, input int vf,
                            input logic [3:0] p, input logic [PW-1:0] px);
    for (int v = 0; v < vs + vb + va + vf; v++) begin
      for (int h = 0; h < hs + hb + ha + hf; h++) begin
        exp_t e;
        logic hv, vv, de;
        hv    = (h >= hs + hb) && (h < hs + hb + ha);
        vv    = (v >= vs + vb) && (v < vs + vb + va);
        de    = hv && vv;
        e.hs  = (h < hs) ^ ~p[0];
        e.vs  = (v < vs) ^ ~p[1];
        e.de  = de ^ ~p[2];
        e.pix = (de ? px : '0) ^ {PW{~p[3]}};
        e.x   = de ? CW'(h - hs - hb) : '0;
        e.y   = de ? CW'(v - vs - vb) : '0;
        q.push_back(e);
      end
    end
  endtask

  // monitor side: compare one item per cycle, away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 R2 R3 R4 R8 raster", 32'({hsync_o, vsync_o, de_o, pix_o, x_o, y_o}), 32'(e));
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pix_i = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R9: reset state, polarity 0 means active-low so idle levels are 1
    chk("R9 idle sync/de", 32'({hsync_o, vsync_o, de_o}), 32'h7);
    chk("R9 idle pix", 32'(pix_o), 32'hFF);
    chk("R9 irq", 32'(irq_o), 32'h0);
    rd(4'd3, d); chk("R9 pol reads 0", 32'(d), 32'h0);
    rd(4'd6, d); chk("R9 hvis reads 0", 32'(d), 32'h0);

    // program: hsync 2, hback 2, hvis 4, hfront 1; vsync 1, vback 1, vvis 3, vfront 1
    wr(4'd4, 16'd1); wr(4'd5, 16'd1); wr(4'd6, 16'd3); wr(4'd7, 16'd0);
    wr(4'd8, 16'd0); wr(4'd9, 16'd0); wr(4'd10, 16'd2); wr(4'd11, 16'd0);
    wr(4'd3, 16'hF);
    rd(4'd6, d); chk("R8 hvis readback", 32'(d), 32'd3);
    rd(4'd10, d); chk("R8 vvis readback", 32'(d), 32'd2);

    wr(4'd0, 16'd1);
    push_frame(2, 2, 4, 1, 1, 1, 3, 1, 4'hF, 8'h5A);
    push_frame(2, 2, 4, 1, 1, 1, 3, 1, 4'hF, 8'h5A);
    drain();

    // R5: stop, everything parks at inactive level
    wr(4'd0, 16'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R5 stopped outputs", 32'({hsync_o, vsync_o, de_o, pix_o, x_o, y_o}), 32'h0);
    end

    // R6/R7: sticky status and mask
    rd(4'd2, d); chk("R6 sticky status", 32'(d), 32'h1);
    chk("R7 masked irq low", 32'(irq_o), 32'h0);
    wr(4'd1, 16'hA);
    rd(4'd1, d);
    wr(4'd1, d | 16'h1);
    rd(4'd1, d); chk("R7 mask rmw keeps bits", 32'(d), 32'hB);
    chk("R7 irq follows mask", 32'(irq_o), 32'h1);
    wr(4'd2, 16'h0);
    rd(4'd2, d); chk("R6 write 0 no effect", 32'(d), 32'h1);
    wr(4'd2, 16'h1);
    rd(4'd2, d); chk("R6 w1c clears", 32'(d), 32'h0);
    chk("R7 irq drops", 32'(irq_o), 32'h0);

    // second run: new polarity, clear collides with frame start, width change mid-frame
    wr(4'd3, 16'h6);
    wr(4'd0, 16'd1);
    push_frame(2, 2, 4, 1, 1, 1, 3, 1, 4'h6, 8'h5A);
    push_frame(2, 2, 6, 1, 1, 1, 3, 1, 4'h6, 8'h5A);
    wr(4'd2, 16'h1);                       // lands in first frame cycle
    rd(4'd2, d); chk("R6 set wins over clear", 32'(d), 32'h1);
    wr(4'd6, 16'd5);                       // R8: applies from next frame
    wr(4'd2, 16'h1);
    rd(4'd2, d); chk("R6 clear mid-frame", 32'(d), 32'h0);
    drain();
    rd(4'd2, d); chk("R6 set by next frame", 32'(d), 32'h1);
    chk("R7 irq asserted", 32'(irq_o), 32'h1);
    wr(4'd0, 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule